// File: doc/BRIEF.md
# OTP Option Programming Sequencer

This block sits on the programmer side of a small device that keeps a 16-bit set of one-time-programmable options. One start pulse runs a complete flow on a three-wire link: a select line, a clock line that idles high and clocks with pairs of negative pulses (a "double clock"), and a bidirectional data line. A full flow powers the device and steers it into programming mode, shifts the option word into the device's register, programs it in two high-voltage stages, and reads it back twice. A read-only flow enters programming mode and returns the option word. All delays and pulse widths are counted in system clock cycles and set by parameters.

The analog supply is not modelled here. The block drives only enables: power-on, a raised programming supply, and a tie of the device's regulator node to the supply. At the end it reports both readback words, LSB = option 0, and a pass flag. The pass flag compares the readbacks against the requested word and ignores the reserved bit positions.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, power-on, raised supply, regulator tie, data drive enable, busy, done and pass are all 0.
- R2: After power-on the select line stays high for at least T_PWR_CYC cycles. It then makes exactly 9 transitions, the first one falling, spaced BURST_HALF_CYC cycles apart, and all of them happen before the clock line first rises.
- R3: A double clock is a high phase, then two low pulses of PULSE_CYC cycles each separated by PULSE_CYC high, then GAP_CYC high. The select level at each double clock follows the fixed order of the chosen flow.
- R4: The write phase drives the data line for 17 double clocks: a 0 first, then option bits 0..15 of (wr_value AND NOT RSV_MASK). Select is high for every bit except bit 15, which is clocked with select low.
- R5: The data line is driven only during the write phase, and never while the raised supply is on.
- R6: The regulator node is tied to the supply exactly twice per full flow. Each tie lasts at least T_PROG_CYC cycles (plus at most 3 cycles of sequencing). During each tie the clock line and select are low and the raised supply is on. The supply is raised before the double clock that starts programming.
- R7: Each readback samples the data line once after each of 16 double clocks and stores the sample for option k in bit k (1 = programmed).
- R8: In a full flow, pass is 1 only when both readback words equal the requested word at every bit that RSV_MASK leaves clear.
- R9: With op_prog = 0 the flow sends 5 double clocks with select low, then 1 with select high, then reads 16 bits into rd_word_a. rd_word_b and pass are 0 at the end.
- R10: A start pulse while busy is ignored, and the running flow carries on unchanged.
- R11: done is a single-cycle pulse, issued once per flow, and it coincides with power-on, raised supply and regulator tie all being 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a flow when idle |
| op_prog | input | 1 | 1 = full write/program/verify flow, 0 = read only |
| wr_value | input | NOPT | Option word to program |
| sel_o | output | 1 | Select line to the device |
| sck_o | output | 1 | Clock line to the device (idles high in mode) |
| sdat_o | output | 1 | Data value driven toward the device |
| sdat_oe | output | 1 | Drive enable for the data line |
| sdat_i | input | 1 | Data line as seen at the pin |
| pwr_on | output | 1 | Device supply enable |
| hv_en | output | 1 | Raise supply to programming level |
| vreg_tie | output | 1 | Tie device regulator node to the supply |
| busy | output | 1 | A flow is in progress |
| done | output | 1 | One-cycle end-of-flow pulse |
| rd_word_a | output | NOPT | First readback word |
| rd_word_b | output | NOPT | Second readback word (full flow only) |
| pass | output | 1 | Both readbacks match the masked request |

## Verification
The assertions watch the electrical safety rules on every cycle. While the regulator node is tied, the clock line and select must be low and the raised supply on. The data line is never driven under raised supply. The waveform engines are never restarted while running, done lasts one cycle with power off, and the operation cannot change mid-flow. Only the bench scenarios can show the ordering. These cover the select level at each double clock, the bit order and masking of the shifted word, the burst spacing and the power-up delay, the tie durations, and the way readback bits and the pass decision follow from what the device returns.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [2:0] {K_NOP, K_WAIT, K_BURST, K_DCLK, K_WRITE, K_READ, K_END} kind_e;
  typedef enum logic [2:0] {TM_PWR, TM_SETTLE, TM_HV, TM_PROG, TM_DIS} tsel_e;

  typedef struct packed {
    logic pwr;
    logic cs;
    logic cx;
    logic oe;
    logic hv;
    logic vreg;
  } lvl_t;

  typedef struct packed {
    kind_e      kind;
    logic [4:0] arg;
    lvl_t       lv;
  } step_t;

  localparam logic [4:0] ENTRY_LAST = 5'd5;

  function automatic lvl_t lv_mk(input logic pwr, input logic cs, input logic cx,
                                 input logic oe, input logic hv, input logic vreg);
    lvl_t l;
    l.pwr = pwr; l.cs = cs; l.cx = cx; l.oe = oe; l.hv = hv; l.vreg = vreg;
    return l;
  endfunction

  function automatic step_t stp(input kind_e k, input logic [4:0] a, input lvl_t l);
    step_t s;
    s.kind = k; s.arg = a; s.lv = l;
    return s;
  endfunction

  // Micro-program: one entry per step, shared mode entry then flow-specific tail.
  function automatic step_t step_of(input logic prog, input logic [4:0] idx);
    step_t s;
    s = stp(K_END, 5'd0, lv_mk(0, 0, 0, 0, 0, 0));
    if (idx <= ENTRY_LAST) begin
      case (idx)
        5'd0: s = stp(K_WAIT,  5'(TM_PWR),    lv_mk(1, 1, 0, 0, 0, 0));
        5'd1: s = stp(K_BURST, 5'd0,          lv_mk(1, 0, 0, 0, 0, 0));
        5'd2: s = stp(K_WAIT,  5'(TM_SETTLE), lv_mk(1, 0, 0, 0, 0, 0));
        5'd3: s = stp(K_WAIT,  5'(TM_SETTLE), lv_mk(1, 0, 1, 0, 0, 0));
        5'd4: s = stp(K_DCLK,  5'd9,          lv_mk(1, 0, 1, 0, 0, 0));
        default: s = stp(K_DCLK, 5'd1,        lv_mk(1, 1, 1, 0, 0, 0));
      endcase
    end else if (prog) begin
      case (idx)
        5'd6:  s = stp(K_DCLK,  5'd1,       lv_mk(1, 1, 1, 0, 0, 0));
        5'd7:  s = stp(K_WRITE, 5'd0,       lv_mk(1, 1, 1, 1, 0, 0));
        5'd8:  s = stp(K_DCLK,  5'd1,       lv_mk(1, 1, 1, 0, 0, 0));
        5'd9:  s = stp(K_WAIT,  5'(TM_HV),  lv_mk(1, 1, 1, 0, 1, 0));
        5'd10: s = stp(K_DCLK,  5'd1,       lv_mk(1, 1, 1, 0, 1, 0));
        5'd11: s = stp(K_NOP,   5'd0,       lv_mk(1, 0, 0, 0, 1, 0));
        5'd12: s = stp(K_WAIT,  5'(TM_PROG), lv_mk(1, 0, 0, 0, 1, 1));
        5'd13: s = stp(K_WAIT,  5'(TM_DIS), lv_mk(1, 0, 0, 0, 1, 0));
        5'd14: s = stp(K_DCLK,  5'd1,       lv_mk(1, 0, 1, 0, 1, 0));
        5'd15: s = stp(K_DCLK,  5'd1,       lv_mk(1, 1, 1, 0, 1, 0));
        5'd16: s = stp(K_NOP,   5'd0,       lv_mk(1, 0, 0, 0, 1, 0));
        5'd17: s = stp(K_WAIT,  5'(TM_PROG), lv_mk(1, 0, 0, 0, 1, 1));
        5'd18: s = stp(K_WAIT,  5'(TM_DIS), lv_mk(1, 0, 0, 0, 0, 0));
        5'd19: s = stp(K_DCLK,  5'd1,       lv_mk(1, 0, 1, 0, 0, 0));
        5'd20: s = stp(K_DCLK,  5'd3,       lv_mk(1, 0, 1, 0, 0, 0));
        5'd21: s = stp(K_DCLK,  5'd1,       lv_mk(1, 1, 1, 0, 0, 0));
        5'd22: s = stp(K_READ,  5'd0,       lv_mk(1, 1, 1, 0, 0, 0));
        5'd23: s = stp(K_DCLK,  5'd1,       lv_mk(1, 0, 1, 0, 0, 0));
        5'd24: s = stp(K_READ,  5'd1,       lv_mk(1, 1, 1, 0, 0, 0));
        default: ;
      endcase
    end else begin
      case (idx)
        5'd6: s = stp(K_DCLK, 5'd5, lv_mk(1, 0, 1, 0, 0, 0));
        5'd7: s = stp(K_DCLK, 5'd1, lv_mk(1, 1, 1, 0, 0, 0));
        5'd8: s = stp(K_READ, 5'd0, lv_mk(1, 1, 1, 0, 0, 0));
        default: ;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/otp_wait_timer.sv
module otp_wait_timer #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] load,
  output logic          run,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        run <= 1'b1;
        cnt <= load - CW'(1);
      end else if (run) begin
        if (cnt == '0) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  AST_TIMER_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) go |-> !run); // R6
endmodule

// File: rtl/otp_sel_burst.sv
module otp_sel_burst #(
  parameter int HALF_CYC = 5,
  parameter int EDGES    = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic sel,
  output logic busy,
  output logic done
);
  localparam int TW = $clog2(HALF_CYC + 1);
  localparam int EW = $clog2(EDGES + 1);

  logic [TW-1:0] tmr;
  logic [EW-1:0] edges;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel   <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      tmr   <= '0;
      edges <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy  <= 1'b1;
        sel   <= 1'b0;
        tmr   <= '0;
        edges <= EW'(1);
      end else if (busy) begin
        if (tmr == TW'(HALF_CYC - 1)) begin
          tmr <= '0;
          if (edges == EW'(EDGES)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            sel   <= ~sel;
            edges <= edges + EW'(1);
          end
        end else begin
          tmr <= tmr + TW'(1);
        end
      end
    end
  end

  AST_BURST_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) go |-> !busy); // R2
endmodule

// File: rtl/otp_dclk_gen.sv
module otp_dclk_gen #(
  parameter int PULSE_CYC = 3,
  parameter int GAP_CYC   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic cx,
  output logic busy,
  output logic done
);
  localparam int LMAX = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int TW   = $clog2(LMAX + 1);

  // Segments: 0 high, 1 low, 2 high, 3 low, 4 trailing high gap.
  logic [2:0]    seg;
  logic [TW-1:0] tmr;
  logic [TW-1:0] seg_last;

  always_comb begin
    seg_last = (seg == 3'd4) ? TW'(GAP_CYC - 1) : TW'(PULSE_CYC - 1);
    cx       = ~seg[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg  <= '0;
      tmr  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        seg  <= '0;
        tmr  <= '0;
      end else if (busy) begin
        if (tmr == seg_last) begin
          tmr <= '0;
          if (seg == 3'd4) begin
            busy <= 1'b0;
            done <= 1'b1;
            seg  <= '0;
          end else begin
            seg <= seg + 3'd1;
          end
        end else begin
          tmr <= tmr + TW'(1);
        end
      end
    end
  end

  AST_DCLK_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) go |-> !busy); // R3
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq #(
  parameter int          NOPT           = 16,
  parameter int          PULSE_CYC      = 2000,
  parameter int          GAP_CYC        = 4000,
  parameter int          BURST_HALF_CYC = 192500,
  parameter int          T_PWR_CYC      = 1100000,
  parameter int          T_SETTLE_CYC   = 25000,
  parameter int          T_HV_CYC       = 250000,
  parameter int          T_PROG_CYC     = 50000000,
  parameter int          T_DIS_CYC      = 5000000,
  parameter logic [15:0] RSV_MASK       = 16'h0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_prog,
  input  logic [NOPT-1:0] wr_value,
  output logic            sel_o,
  output logic            sck_o,
  output logic            sdat_o,
  output logic            sdat_oe,
  input  logic            sdat_i,
  output logic            pwr_on,
  output logic            hv_en,
  output logic            vreg_tie,
  output logic            busy,
  output logic            done,
  output logic [NOPT-1:0] rd_word_a,
  output logic [NOPT-1:0] rd_word_b,
  output logic            pass
);
  import otp_seq_pkg::*;

  localparam int TSUM  = T_PWR_CYC + T_SETTLE_CYC + T_HV_CYC + T_PROG_CYC + T_DIS_CYC;
  localparam int TMR_W = $clog2(TSUM + 1) + 1;
  localparam int IDXW  = $clog2(NOPT);
  localparam int CNTW  = $clog2(NOPT + 1);
  localparam logic [NOPT-1:0] KEEP = ~RSV_MASK[NOPT-1:0];

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_WAIT, PH_DCLK, PH_BURST} ph_e;
  typedef enum logic [1:0] {X_NONE, X_WR, X_RD} xfer_e;

  function automatic logic [NOPT-1:0] masked_write(input logic [NOPT-1:0] v);
    return v & KEEP;
  endfunction

  function automatic logic words_ok(input logic [NOPT-1:0] a, input logic [NOPT-1:0] b,
                                    input logic [NOPT-1:0] want);
    return (((a ^ want) & KEEP) == '0) && (((b ^ want) & KEEP) == '0);
  endfunction

  function automatic logic [TMR_W-1:0] wait_len(input logic [4:0] sel);
    case (tsel_e'(sel[2:0]))
      TM_PWR:    return TMR_W'(T_PWR_CYC);
      TM_SETTLE: return TMR_W'(T_SETTLE_CYC);
      TM_HV:     return TMR_W'(T_HV_CYC);
      TM_PROG:   return TMR_W'(T_PROG_CYC);
      default:   return TMR_W'(T_DIS_CYC);
    endcase
  endfunction

  ph_e             ph;
  xfer_e           xfer;
  logic [4:0]      idx;
  logic            op_r;
  lvl_t            lv;
  logic [4:0]      remain;
  logic [CNTW-1:0] bitn;
  logic            rd_sel;
  logic            dat_r;
  logic [NOPT-1:0] wmask;
  step_t           cur;

  // Named events between the sequencer and its engines.
  logic dclk_go, dclk_busy, dclk_done, dclk_cx;
  logic burst_go, burst_busy, burst_done, burst_sel;
  logic wait_go, wait_run, wait_done;
  logic step_go, dclk_more, last_write_bit;

  always_comb begin
    cur     = step_of(op_r, idx);
    step_go = (ph == PH_START);
    case (xfer)
      X_WR:    dclk_more = (bitn != CNTW'(NOPT));
      X_RD:    dclk_more = (bitn != CNTW'(NOPT - 1));
      default: dclk_more = (remain != 5'd1);
    endcase
    last_write_bit = (xfer == X_WR) && (bitn == CNTW'(NOPT - 1));
    dclk_go  = (step_go && (cur.kind inside {K_DCLK, K_WRITE, K_READ}))
             || (ph == PH_DCLK && dclk_done && dclk_more);
    burst_go = step_go && (cur.kind == K_BURST);
    wait_go  = step_go && (cur.kind == K_WAIT);
  end

  otp_dclk_gen #(.PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)) u_dclk (
    .clk(clk), .rst_n(rst_n), .go(dclk_go), .cx(dclk_cx), .busy(dclk_busy), .done(dclk_done)
  );

  otp_sel_burst #(.HALF_CYC(BURST_HALF_CYC), .EDGES(9)) u_burst (
    .clk(clk), .rst_n(rst_n), .go(burst_go), .sel(burst_sel), .busy(burst_busy), .done(burst_done)
  );

  otp_wait_timer #(.CW(TMR_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .go(wait_go), .load(wait_len(cur.arg)), .run(wait_run), .done(wait_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      xfer      <= X_NONE;
      idx       <= '0;
      op_r      <= 1'b0;
      lv        <= '0;
      remain    <= '0;
      bitn      <= '0;
      rd_sel    <= 1'b0;
      dat_r     <= 1'b0;
      wmask     <= '0;
      rd_word_a <= '0;
      rd_word_b <= '0;
      pass      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            op_r      <= op_prog;
            wmask     <= masked_write(wr_value);
            idx       <= '0;
            rd_word_a <= '0;
            rd_word_b <= '0;
            pass      <= 1'b0;
            ph        <= PH_START;
          end
        end
        PH_START: begin
          lv <= cur.lv;
          case (cur.kind)
            K_NOP:   idx <= idx + 5'd1;
            K_WAIT:  ph <= PH_WAIT;
            K_BURST: ph <= PH_BURST;
            K_DCLK: begin
              remain <= cur.arg;
              xfer   <= X_NONE;
              ph     <= PH_DCLK;
            end
            K_WRITE: begin
              xfer  <= X_WR;
              bitn  <= '0;
              dat_r <= 1'b0;
              ph    <= PH_DCLK;
            end
            K_READ: begin
              xfer   <= X_RD;
              bitn   <= '0;
              rd_sel <= cur.arg[0];
              ph     <= PH_DCLK;
            end
            default: begin
              pass <= op_r && words_ok(rd_word_a, rd_word_b, wmask);
              done <= 1'b1;
              ph   <= PH_IDLE;
            end
          endcase
        end
        PH_WAIT: begin
          if (wait_done) begin
            idx <= idx + 5'd1;
            ph  <= PH_START;
          end
        end
        PH_BURST: begin
          if (burst_done) begin
            idx <= idx + 5'd1;
            ph  <= PH_START;
          end
        end
        PH_DCLK: begin
          if (dclk_done) begin
            case (xfer)
              X_WR: begin
                if (dclk_more) begin
                  dat_r <= wmask[bitn[IDXW-1:0]];
                  if (last_write_bit) lv.cs <= 1'b0;
                end
                bitn <= bitn + CNTW'(1);
              end
              X_RD: begin
                if (rd_sel) rd_word_b[bitn[IDXW-1:0]] <= sdat_i;
                else        rd_word_a[bitn[IDXW-1:0]] <= sdat_i;
                bitn <= bitn + CNTW'(1);
              end
              default: remain <= remain - 5'd1;
            endcase
            if (!dclk_more) begin
              idx  <= idx + 5'd1;
              xfer <= X_NONE;
              ph   <= PH_START;
            end
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    sel_o    = burst_busy ? burst_sel : lv.cs;
    sck_o    = dclk_busy ? dclk_cx : lv.cx;
    sdat_o   = dat_r;
    sdat_oe  = lv.oe;
    pwr_on   = lv.pwr;
    hv_en    = lv.hv;
    vreg_tie = lv.vreg;
    busy     = (ph != PH_IDLE);
  end

  AST_TIE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_tie |-> (!sck_o && !sel_o && hv_en)); // R6
  AST_HV_BEFORE_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vreg_tie) |-> $past(hv_en)); // R6
  AST_DRIVE_LOW_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    sdat_oe |-> (pwr_on && !hv_en)); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_POWER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!pwr_on && !hv_en && !vreg_tie && !busy)); // R11
  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_r)); // R10
endmodule

// File: tb/sim_otp_prog_seq.sv
module sim_otp_prog_seq;
  localparam int          P     = 3;
  localparam int          G     = 4;
  localparam int          HALF  = 5;
  localparam int          TPWR  = 20;
  localparam int          TSET  = 8;
  localparam int          THV   = 10;
  localparam int          TPROG = 30;
  localparam int          TDIS  = 12;
  localparam logic [15:0] MASK  = 16'h0300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic op_prog = 1'b0;
  logic [15:0] wr_value = '0;
  logic sel_o, sck_o, sdat_o, sdat_oe, pwr_on, hv_en, vreg_tie, busy, done, pass;
  logic sdat_i = 1'b0;
  logic [15:0] rd_word_a, rd_word_b;

  always #2 clk = ~clk;

  otp_prog_seq #(
    .NOPT(16), .PULSE_CYC(P), .GAP_CYC(G), .BURST_HALF_CYC(HALF), .T_PWR_CYC(TPWR),
    .T_SETTLE_CYC(TSET), .T_HV_CYC(THV), .T_PROG_CYC(TPROG), .T_DIS_CYC(TDIS), .RSV_MASK(MASK)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog), .wr_value(wr_value),
    .sel_o(sel_o), .sck_o(sck_o), .sdat_o(sdat_o), .sdat_oe(sdat_oe), .sdat_i(sdat_i),
    .pwr_on(pwr_on), .hv_en(hv_en), .vreg_tie(vreg_tie), .busy(busy), .done(done),
    .rd_word_a(rd_word_a), .rd_word_b(rd_word_b), .pass(pass)
  );

  typedef struct {
    bit    cs;
    bit    oe;
    bit    d;
    bit    hv;
    bit    drv;
    string tag;
  } item_t;

  item_t exp_q[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // Trackers filled by the monitor.
  int  low_len = 0, pulses = 0, done_cnt = 0;
  int  vreg_runs = 0, vreg_len = 0, vreg_bad_len = 0;
  int  pwr_rise_cyc = -1, burst_n = 0, burst_first_cyc = -1, burst_last_cyc = -1;
  int  burst_bad_gap = 0;
  bit  burst_first_fall = 1'b0, seen_cx_rise = 1'b0;
  bit  prev_cx = 1'b0, prev_sel = 1'b0, prev_pwr = 1'b0, prev_vreg = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(input bit cs, input bit oe, input bit d, input bit hv, input bit drv, input string tag);
    item_t it;
    it.cs = cs; it.oe = oe; it.d = d; it.hv = hv; it.drv = drv; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic push_entry();
    for (int i = 0; i < 9; i++) push(0, 0, 0, 0, 0, "R3");
    push(1, 0, 0, 0, 0, "R3");
  endtask

  task automatic push_full(input logic [15:0] wm, input logic [15:0] ta, input logic [15:0] tb);
    push_entry();
    push(1, 0, 0, 0, 0, "R3");
    push(1, 1, 0, 0, 0, "R4");
    for (int i = 0; i < 15; i++) push(1, 1, wm[i], 0, 0, "R4");
    push(0, 1, wm[15], 0, 0, "R4");
    push(1, 0, 0, 0, 0, "R3");
    push(1, 0, 0, 1, 0, "R6");
    push(0, 0, 0, 1, 0, "R6");
    push(1, 0, 0, 1, 0, "R6");
    push(0, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 3; i++) push(0, 0, 0, 0, 0, "R3");
    push(1, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 16; i++) push(1, 0, 0, 0, ta[i], "R7");
    push(0, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 16; i++) push(1, 0, 0, 0, tb[i], "R7");
  endtask

  task automatic push_read(input logic [15:0] ta);
    push_entry();
    for (int i = 0; i < 5; i++) push(0, 0, 0, 0, 0, "R9");
    push(1, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 16; i++) push(1, 0, 0, 0, ta[i], "R9");
  endtask

  // Monitor: detects double clocks at the pins and scores them against the queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (sck_o == 1'b0) low_len++;
      else begin
        if (prev_cx == 1'b0 && pwr_on) seen_cx_rise = 1'b1;
        if (prev_cx == 1'b0 && low_len == P) begin
          pulses++;
          if (pulses % 2 == 0) begin
            if (exp_q.size() == 0) chk(0, "R3", "unexpected double clock", pulses / 2, 0);
            else begin
              item_t it;
              it = exp_q.pop_front();
              chk(sel_o == it.cs, it.tag, "select level at double clock", sel_o, it.cs);
              chk(sdat_oe == it.oe, "R5", "data drive enable at double clock", sdat_oe, it.oe);
              if (it.oe) chk(sdat_o == it.d, it.tag, "written data bit", sdat_o, it.d);
              chk(hv_en == it.hv, it.tag, "raised supply at double clock", hv_en, it.hv);
              chk(vreg_tie == 1'b0, "R6", "tie during double clock", vreg_tie, 0);
              sdat_i <= it.drv;
            end
          end
        end
        low_len = 0;
      end
      if (pwr_on && !prev_pwr) pwr_rise_cyc = cyc;
      if (pwr_on && prev_pwr && !seen_cx_rise && sel_o != prev_sel) begin
        burst_n++;
        if (burst_n == 1) begin
          burst_first_cyc = cyc;
          burst_first_fall = (sel_o == 1'b0);
        end else if (cyc - burst_last_cyc != HALF) burst_bad_gap++;
        burst_last_cyc = cyc;
      end
      if (vreg_tie) vreg_len++;
      if (!vreg_tie && prev_vreg) begin
        vreg_runs++;
        if (vreg_len < TPROG || vreg_len > TPROG + 3) vreg_bad_len++;
        vreg_len = 0;
      end
      prev_cx = sck_o; prev_sel = sel_o; prev_pwr = pwr_on; prev_vreg = vreg_tie;
    end
  end

  always @(posedge clk) cyc++;

  task automatic clear_tracks();
    pulses = 0; done_cnt = 0; vreg_runs = 0; vreg_len = 0; vreg_bad_len = 0;
    burst_n = 0; burst_bad_gap = 0; burst_first_cyc = -1; burst_last_cyc = -1;
    pwr_rise_cyc = -1; seen_cx_rise = 1'b0; burst_first_fall = 1'b0;
  endtask

  task automatic kick(input bit prog, input logic [15:0] wv);
    @(negedge clk);
    op_prog = prog; wr_value = wv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || start) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic end_checks(input bit full);
    chk(exp_q.size() == 0, "R3", "double clocks left unsent", exp_q.size(), 0);
    chk(done_cnt == 1, "R11", "done pulses per flow", done_cnt, 1);
    chk(!pwr_on && !hv_en && !vreg_tie && !sdat_oe, "R11", "supplies off after flow",
        {pwr_on, hv_en, vreg_tie, sdat_oe}, 0);
    chk(burst_n == 9, "R2", "select burst transitions", burst_n, 9);
    chk(burst_first_fall, "R2", "first burst transition falling", burst_first_fall, 1);
    chk(burst_bad_gap == 0, "R2", "burst spacing errors", burst_bad_gap, 0);
    chk(burst_first_cyc - pwr_rise_cyc >= TPWR, "R2", "power-up hold before burst",
        burst_first_cyc - pwr_rise_cyc, TPWR);
    if (full) begin
      chk(vreg_runs == 2, "R6", "regulator tie count", vreg_runs, 2);
      chk(vreg_bad_len == 0, "R6", "regulator tie length errors", vreg_bad_len, 0);
    end else begin
      chk(vreg_runs == 0, "R9", "no tie in read-only flow", vreg_runs, 0);
    end
  endtask

  task automatic full_flow(input logic [15:0] wv, input logic [15:0] ta, input logic [15:0] tb,
                           input bit exp_pass, input bit poke_start);
    logic [15:0] wm;
    wm = wv & ~MASK;
    clear_tracks();
    push_full(wm, ta, tb);
    kick(1'b1, wv);
    if (poke_start) begin
      repeat (300) @(negedge clk);
      chk(busy, "R10", "flow still running at poke", busy, 1);
      op_prog = 1'b0; wr_value = 16'hFFFF; start = 1'b1;   // R10: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    wait_idle();
    end_checks(1'b1);
    chk(rd_word_a == ta, "R7", "first readback word", rd_word_a, ta);
    chk(rd_word_b == tb, "R7", "second readback word", rd_word_b, tb);
    chk(pass == exp_pass, "R8", "pass flag", pass, exp_pass);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!pwr_on && !hv_en && !vreg_tie && !sdat_oe && !busy && !done && !pass, "R1",
        "outputs in reset", {pwr_on, hv_en, vreg_tie, sdat_oe, busy, done, pass}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!pwr_on && !busy && !sdat_oe, "R1", "idle after reset release", {pwr_on, busy, sdat_oe}, 0);

    // R4 R7 R8: clean program and verify, reserved bit 8 requested but written 0.
    full_flow(16'hA5C3, 16'hA5C3 & ~MASK, 16'hA5C3 & ~MASK, 1'b1, 1'b0);
    // R8: second readback differs in bit 4 -> fail.
    full_flow(16'h0F0F, 16'h0C0F, 16'h0C1F, 1'b0, 1'b0);
    // R8 R10: readback differs only in reserved bits -> pass; stray start ignored.
    full_flow(16'h7F5A, 16'h7F5A ^ 16'h0100, 16'h7E5A, 1'b1, 1'b1);

    // R9: read-only flow.
    clear_tracks();
    push_read(16'h1234);
    kick(1'b0, 16'hFFFF);
    wait_idle();
    end_checks(1'b0);
    chk(rd_word_a == 16'h1234, "R9", "read-only word", rd_word_a, 16'h1234);
    chk(rd_word_b == 16'h0000, "R9", "read-only second word", rd_word_b, 0);
    chk(pass == 1'b0, "R9", "read-only pass flag", pass, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 150000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule